// File: doc/BRIEF.md
# Call Gate Stack Switch Sequencer

This block performs the stack-switching part of a call through a gate into a more privileged code segment. The descriptor of the gate has already been fetched and accepted by the caller. One pulse on `start_i` hands the block the target privilege level, the gate's entry point, its parameter count and the caller's context. The block then works out where the inner stack pointer and stack selector are kept in the current task-state segment, reads both and validates the new stack segment. Only after every check has passed does it write the caller's context and parameters onto the new stack and commit the new privilege level, code selector, instruction pointer and stack.

A single word-wide memory port carries all traffic. Reads are registered: data for a request issued in one cycle is sampled in the next. `mem_wide_o` selects a 4-byte access when high and a 2-byte access when low. The new stack segment's descriptor attributes are supplied combinationally for the selector shown on `ss_sel_o`.

The FSM has these states: IDLE, TSS_CHK, RD_ESP, RD_SS, SS_GET, SS_CHK, PUSH_SS, PUSH_ESP, PAR_RD, PAR_WR, PUSH_CS, PUSH_EIP, DONE and FAULT. The transitions are:
- IDLE→TSS_CHK on start.
- TSS_CHK→FAULT when the TSS limit check fails, otherwise TSS_CHK→RD_ESP.
- RD_ESP→RD_SS→SS_GET→SS_CHK.
- SS_CHK→FAULT on any stack-segment check failure, otherwise SS_CHK→PUSH_SS.
- PUSH_SS→PUSH_ESP.
- PUSH_ESP→PAR_RD when the count is non-zero, otherwise PUSH_ESP→PUSH_CS.
- PAR_RD→PAR_WR.
- PAR_WR→PAR_RD while parameters remain, PAR_WR→PUSH_CS after the last one.
- PUSH_CS→PUSH_EIP→DONE→IDLE.
- FAULT→IDLE.

Top module: `gate_stack_switch`

## Requirements
- R1: After reset, busy, done and fault are low, and cpl, cs, eip, ss and esp are all zero.
- R2: With a 32-bit TSS (`tss_wide_i`=1), the entry offset is target DPL×8+4. The stack pointer is read as 4 bytes at base+offset, and the selector is read as 2 bytes at base+offset+4. If offset+7 exceeds the TSS limit, a TS fault (kind 1) is raised carrying `cur_tss_sel_i`.
- R3: With a 16-bit TSS, the entry offset is DPL×4+2. The stack pointer is read as 2 bytes and zero-extended, and the selector is read at offset+2. If offset+4 exceeds the limit, a TS fault is raised carrying `cur_tss_sel_i`.
- R4: A TS fault (kind 1) carrying the new stack selector is raised when any of these holds, tested in this priority:
  - the selector is null (bits 15:2 zero);
  - the selector is not in table range;
  - its RPL (bits 1:0) differs from the target DPL;
  - the segment DPL differs from the target DPL;
  - the segment is not a writable data segment.
- R5: When every R4 check passes but the new stack segment is not present, a stack fault (kind 2) carrying its selector is raised.
- R6: The room needed is count×4+16 for a 32-bit gate and count×2+8 for a 16-bit gate. It is granted only when need ≤ new ESP and new ESP−1 ≤ the stack limit. Otherwise a stack fault (kind 2) carrying the selector is raised.
- R7: The parameter count used is bits 4:0 of `gate_pcnt_i`, and higher bits are ignored.
- R8: The new stack is written downward from ss_base+new ESP in this order: old SS, old ESP, the parameters (deepest first, the deepest being at old_ss_base+old_esp+(count−1)×size), old CS, old EIP.
- R9: A 32-bit gate writes 4-byte items and zero-extends selectors. A 16-bit gate writes 2-byte items holding the low halves of ESP and EIP.
- R10: On success `done_o` pulses for one cycle, and in that cycle the committed state is:
  - cpl = target DPL;
  - cs = code selector with RPL replaced by that DPL;
  - eip = gate offset, upper half cleared for a 16-bit gate;
  - ss = new selector;
  - esp = new ESP − need.
- R11: On any fault, no memory write occurs and the committed state is unchanged. `fault_o` pulses for one cycle with `fault_kind_o` and `fault_sel_o` valid.
- R12: `busy_o` is high from the cycle after an accepted start until the done or fault cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sequence (accepted in IDLE only) |
| cur_tss_sel_i | input | 16 | Selector of the running TSS, reported on TSS limit faults |
| tss_base_i | input | 32 | Linear base of the running TSS |
| tss_limit_i | input | 32 | Limit of the running TSS |
| tss_wide_i | input | 1 | 1: 32-bit TSS layout, 0: 16-bit |
| code_sel_i | input | 16 | Target code selector from the gate |
| code_dpl_i | input | 2 | DPL of the target code segment |
| gate_wide_i | input | 1 | 1: 32-bit gate, 0: 16-bit gate |
| gate_offset_i | input | 32 | Entry offset from the gate |
| gate_pcnt_i | input | 8 | Raw parameter count field |
| old_cs_i | input | 16 | Caller code selector |
| old_eip_i | input | 32 | Caller return offset |
| old_ss_i | input | 16 | Caller stack selector |
| old_esp_i | input | 32 | Caller stack pointer |
| old_ss_base_i | input | 32 | Linear base of the caller stack |
| ss_sel_o | output | 16 | Selector whose descriptor is being examined |
| ss_in_range_i | input | 1 | Selector index lies inside its table |
| ss_present_i | input | 1 | New stack segment present |
| ss_dpl_i | input | 2 | New stack segment DPL |
| ss_writable_i | input | 1 | Segment is a writable data segment |
| ss_base_i | input | 32 | New stack linear base |
| ss_limit_i | input | 32 | New stack limit |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high |
| mem_wide_o | output | 1 | 4-byte access when high, 2-byte when low |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_kind_o | output | 2 | 1: TS fault, 2: stack fault |
| fault_sel_o | output | 16 | Selector reported with the fault |
| cpl_o | output | 2 | Committed privilege level |
| cs_o | output | 16 | Committed code selector |
| eip_o | output | 32 | Committed instruction pointer |
| ss_o | output | 16 | Committed stack selector |
| esp_o | output | 32 | Committed stack pointer |

## Verification
The bench targets the exact TSS limit boundaries for both layouts and the exact room boundary against both the new ESP and the stack limit; an off-by-one comparison would flip pass and fault there. A 16-bit TSS entry is read next to a stored selector, so a design that failed to zero-extend would report a corrupted ESP. A 16-bit gate is checked for untouched bytes above the first item, which exposes writes of the wrong width. Parameter order is checked word by word, and a count field with set high bits is used to catch a missing mask. A fault that meets two causes at once must report the TS fault first, and every fault must leave memory and the committed state untouched.

// File: rtl/gss_pkg.sv
`timescale 1ns/1ps
package gss_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int CNT_W  = 5;
    localparam int RAW_CNT_W = 8;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_TS   = 2'd1,
        FK_SS   = 2'd2
    } fault_kind_e;

    typedef enum logic [1:0] {
        CHK_OK,
        CHK_TS,
        CHK_SS
    } chk_e;

    typedef enum logic [3:0] {
        S_IDLE, S_TSS_CHK, S_RD_ESP, S_RD_SS, S_SS_GET, S_SS_CHK,
        S_PUSH_SS, S_PUSH_ESP, S_PAR_RD, S_PAR_WR, S_PUSH_CS,
        S_PUSH_EIP, S_DONE, S_FAULT
    } state_e;
endpackage

// File: rtl/gss_tss_locate.sv
`timescale 1ns/1ps
// Locates the inner stack entry inside the task-state segment and
// checks it against the segment limit.
module gss_tss_locate
    import gss_pkg::*;
(
    input  logic              tss_wide_i,
    input  logic [1:0]        dpl_i,
    input  logic [WORD_W-1:0] tss_limit_i,
    output logic [WORD_W-1:0] esp_off_o,
    output logic [WORD_W-1:0] ss_off_o,
    output logic              over_o
);
    localparam int OFF_W = 6;

    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] span;

    always_comb begin
        if (tss_wide_i) begin
            base = {1'b0, dpl_i, 3'b100};   // dpl*8 + 4
            span = OFF_W'(7);
        end else begin
            base = {2'b00, dpl_i, 2'b10};   // dpl*4 + 2
            span = OFF_W'(4);
        end
        esp_off_o = WORD_W'(base);
        ss_off_o  = esp_off_o + (tss_wide_i ? WORD_W'(4) : WORD_W'(2));
        over_o    = (WORD_W'(base) + WORD_W'(span)) > tss_limit_i;
    end
endmodule

// File: rtl/gss_ss_validate.sv
`timescale 1ns/1ps
// Validates the new stack selector, its descriptor and the room left on it.
module gss_ss_validate
    import gss_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [1:0]        code_dpl_i,
    input  logic              in_range_i,
    input  logic              present_i,
    input  logic [1:0]        seg_dpl_i,
    input  logic              writable_i,
    input  logic [WORD_W-1:0] esp_i,
    input  logic [WORD_W-1:0] limit_i,
    input  logic              gate_wide_i,
    input  logic [CNT_W-1:0]  pcnt_i,
    output chk_e              verdict_o,
    output logic [WORD_W-1:0] need_o
);
    logic room_ok;

    always_comb begin
        if (gate_wide_i)
            need_o = WORD_W'({pcnt_i, 2'b00}) + WORD_W'(16);
        else
            need_o = WORD_W'({pcnt_i, 1'b0}) + WORD_W'(8);
        room_ok = (need_o <= esp_i) && ((esp_i - WORD_W'(1)) <= limit_i);
    end

    always_comb begin
        if (sel_i[SEL_W-1:2] == '0)        verdict_o = CHK_TS;
        else if (!in_range_i)              verdict_o = CHK_TS;
        else if (sel_i[1:0] != code_dpl_i) verdict_o = CHK_TS;
        else if (seg_dpl_i != code_dpl_i)  verdict_o = CHK_TS;
        else if (!writable_i)              verdict_o = CHK_TS;
        else if (!present_i)               verdict_o = CHK_SS;
        else if (!room_ok)                 verdict_o = CHK_SS;
        else                               verdict_o = CHK_OK;
    end
endmodule

// File: rtl/gate_stack_switch.sv
`timescale 1ns/1ps
// Sequencer for the stack switch of a more-privileged call through a gate.
module gate_stack_switch
    import gss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [SEL_W-1:0]     cur_tss_sel_i,
    input  logic [WORD_W-1:0]    tss_base_i,
    input  logic [WORD_W-1:0]    tss_limit_i,
    input  logic                 tss_wide_i,
    input  logic [SEL_W-1:0]     code_sel_i,
    input  logic [1:0]           code_dpl_i,
    input  logic                 gate_wide_i,
    input  logic [WORD_W-1:0]    gate_offset_i,
    input  logic [RAW_CNT_W-1:0] gate_pcnt_i,
    input  logic [SEL_W-1:0]     old_cs_i,
    input  logic [WORD_W-1:0]    old_eip_i,
    input  logic [SEL_W-1:0]     old_ss_i,
    input  logic [WORD_W-1:0]    old_esp_i,
    input  logic [WORD_W-1:0]    old_ss_base_i,
    output logic [SEL_W-1:0]     ss_sel_o,
    input  logic                 ss_in_range_i,
    input  logic                 ss_present_i,
    input  logic [1:0]           ss_dpl_i,
    input  logic                 ss_writable_i,
    input  logic [WORD_W-1:0]    ss_base_i,
    input  logic [WORD_W-1:0]    ss_limit_i,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic                 mem_wide_o,
    output logic [WORD_W-1:0]    mem_addr_o,
    output logic [WORD_W-1:0]    mem_wdata_o,
    input  logic [WORD_W-1:0]    mem_rdata_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 fault_o,
    output logic [1:0]           fault_kind_o,
    output logic [SEL_W-1:0]     fault_sel_o,
    output logic [1:0]           cpl_o,
    output logic [SEL_W-1:0]     cs_o,
    output logic [WORD_W-1:0]    eip_o,
    output logic [SEL_W-1:0]     ss_o,
    output logic [WORD_W-1:0]    esp_o
);
    localparam int HALF_W = WORD_W / 2;
    localparam int WCNT_W = CNT_W + 1;

    state_e state_q, state_d;

    // Latched operation context
    logic [SEL_W-1:0]  tss_sel_q, code_sel_q, old_cs_q, old_ss_q, new_ss_q;
    logic [WORD_W-1:0] tss_base_q, tss_limit_q, gate_off_q, old_eip_q;
    logic [WORD_W-1:0] old_esp_q, old_base_q, new_esp_q, ss_base_q, wp_q;
    logic              tss_wide_q, gate_wide_q;
    logic [1:0]        dpl_q;
    logic [CNT_W-1:0]  pcnt_q, par_left_q;
    fault_kind_e       fault_kind_q;
    logic [SEL_W-1:0]  fault_sel_q;

    // Committed state
    logic [1:0]        cpl_q;
    logic [SEL_W-1:0]  cs_q, ss_q;
    logic [WORD_W-1:0] eip_q, esp_q;

    logic [WORD_W-1:0] esp_off, ss_off, need, isz, par_ofs, push_addr;
    logic              tss_over;
    chk_e              verdict;
    logic              is_write;

    gss_tss_locate u_locate (
        .tss_wide_i  (tss_wide_q),
        .dpl_i       (dpl_q),
        .tss_limit_i (tss_limit_q),
        .esp_off_o   (esp_off),
        .ss_off_o    (ss_off),
        .over_o      (tss_over)
    );

    gss_ss_validate u_validate (
        .sel_i       (new_ss_q),
        .code_dpl_i  (dpl_q),
        .in_range_i  (ss_in_range_i),
        .present_i   (ss_present_i),
        .seg_dpl_i   (ss_dpl_i),
        .writable_i  (ss_writable_i),
        .esp_i       (new_esp_q),
        .limit_i     (ss_limit_i),
        .gate_wide_i (gate_wide_q),
        .pcnt_i      (pcnt_q),
        .verdict_o   (verdict),
        .need_o      (need)
    );

    assign isz       = gate_wide_q ? WORD_W'(4) : WORD_W'(2);
    assign par_ofs   = WORD_W'(par_left_q - CNT_W'(1)) << (gate_wide_q ? 2 : 1);
    assign push_addr = ss_base_q + wp_q - isz;
    assign is_write  = (state_q == S_PUSH_SS) || (state_q == S_PUSH_ESP) ||
                       (state_q == S_PAR_WR)  || (state_q == S_PUSH_CS)  ||
                       (state_q == S_PUSH_EIP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_TSS_CHK;
            S_TSS_CHK:  state_d = tss_over ? S_FAULT : S_RD_ESP;
            S_RD_ESP:   state_d = S_RD_SS;
            S_RD_SS:    state_d = S_SS_GET;
            S_SS_GET:   state_d = S_SS_CHK;
            S_SS_CHK:   state_d = (verdict == CHK_OK) ? S_PUSH_SS : S_FAULT;
            S_PUSH_SS:  state_d = S_PUSH_ESP;
            S_PUSH_ESP: state_d = (pcnt_q != '0) ? S_PAR_RD : S_PUSH_CS;
            S_PAR_RD:   state_d = S_PAR_WR;
            S_PAR_WR:   state_d = (par_left_q == CNT_W'(1)) ? S_PUSH_CS : S_PAR_RD;
            S_PUSH_CS:  state_d = S_PUSH_EIP;
            S_PUSH_EIP: state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            S_FAULT:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_wide_o  = gate_wide_q;
        mem_addr_o  = push_addr;
        mem_wdata_o = '0;
        unique case (state_q)
            S_RD_ESP: begin
                mem_req_o  = 1'b1;
                mem_wide_o = tss_wide_q;
                mem_addr_o = tss_base_q + esp_off;
            end
            S_RD_SS: begin
                mem_req_o  = 1'b1;
                mem_wide_o = 1'b0;
                mem_addr_o = tss_base_q + ss_off;
            end
            S_PUSH_SS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = WORD_W'(old_ss_q);
            end
            S_PUSH_ESP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = gate_wide_q ? old_esp_q : WORD_W'(old_esp_q[HALF_W-1:0]);
            end
            S_PAR_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = old_base_q + old_esp_q + par_ofs;
            end
            S_PAR_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = gate_wide_q ? mem_rdata_i : WORD_W'(mem_rdata_i[HALF_W-1:0]);
            end
            S_PUSH_CS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = WORD_W'(old_cs_q);
            end
            S_PUSH_EIP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = gate_wide_q ? old_eip_q : WORD_W'(old_eip_q[HALF_W-1:0]);
            end
            default: ;
        endcase
        busy_o = (state_q != S_IDLE) && (state_q != S_DONE) && (state_q != S_FAULT);
        done_o  = (state_q == S_DONE);
        fault_o = (state_q == S_FAULT);
    end

    assign ss_sel_o     = new_ss_q;
    assign fault_kind_o = fault_kind_q;
    assign fault_sel_o  = fault_sel_q;
    assign cpl_o        = cpl_q;
    assign cs_o         = cs_q;
    assign eip_o        = eip_q;
    assign ss_o         = ss_q;
    assign esp_o        = esp_q;

    // Operation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tss_sel_q    <= '0;
            tss_base_q   <= '0;
            tss_limit_q  <= '0;
            tss_wide_q   <= 1'b0;
            code_sel_q   <= '0;
            dpl_q        <= '0;
            gate_wide_q  <= 1'b0;
            gate_off_q   <= '0;
            pcnt_q       <= '0;
            par_left_q   <= '0;
            old_cs_q     <= '0;
            old_eip_q    <= '0;
            old_ss_q     <= '0;
            old_esp_q    <= '0;
            old_base_q   <= '0;
            new_esp_q    <= '0;
            new_ss_q     <= '0;
            ss_base_q    <= '0;
            wp_q         <= '0;
            fault_kind_q <= FK_NONE;
            fault_sel_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    tss_sel_q   <= cur_tss_sel_i;
                    tss_base_q  <= tss_base_i;
                    tss_limit_q <= tss_limit_i;
                    tss_wide_q  <= tss_wide_i;
                    code_sel_q  <= code_sel_i;
                    dpl_q       <= code_dpl_i;
                    gate_wide_q <= gate_wide_i;
                    gate_off_q  <= gate_offset_i;
                    pcnt_q      <= gate_pcnt_i[CNT_W-1:0];
                    par_left_q  <= gate_pcnt_i[CNT_W-1:0];
                    old_cs_q    <= old_cs_i;
                    old_eip_q   <= old_eip_i;
                    old_ss_q    <= old_ss_i;
                    old_esp_q   <= old_esp_i;
                    old_base_q  <= old_ss_base_i;
                end
                S_TSS_CHK: if (tss_over) begin
                    fault_kind_q <= FK_TS;
                    fault_sel_q  <= tss_sel_q;
                end
                S_RD_SS:
                    new_esp_q <= tss_wide_q ? mem_rdata_i : WORD_W'(mem_rdata_i[HALF_W-1:0]);
                S_SS_GET: begin
                    new_ss_q <= mem_rdata_i[SEL_W-1:0];
                    wp_q     <= new_esp_q;
                end
                S_SS_CHK: begin
                    ss_base_q <= ss_base_i;
                    if (verdict != CHK_OK) begin
                        fault_kind_q <= (verdict == CHK_TS) ? FK_TS : FK_SS;
                        fault_sel_q  <= new_ss_q;
                    end
                end
                S_PAR_WR: begin
                    wp_q       <= wp_q - isz;
                    par_left_q <= par_left_q - CNT_W'(1);
                end
                S_PUSH_SS, S_PUSH_ESP, S_PUSH_CS, S_PUSH_EIP:
                    wp_q <= wp_q - isz;
                default: ;
            endcase
        end
    end

    // Committed state, written only once every check has passed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_q <= '0;
            cs_q  <= '0;
            eip_q <= '0;
            ss_q  <= '0;
            esp_q <= '0;
        end else if (state_q == S_PUSH_EIP) begin
            cpl_q <= dpl_q;
            cs_q  <= {code_sel_q[SEL_W-1:2], dpl_q};
            eip_q <= gate_wide_q ? gate_off_q : WORD_W'(gate_off_q[HALF_W-1:0]);
            ss_q  <= new_ss_q;
            esp_q <= wp_q - isz;
        end
    end

    // Observation registers for the assertions below
    logic              wr_seen_q;
    logic [WCNT_W-1:0] wr_cnt_q;
    logic [WORD_W-1:0] last_wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
            wr_cnt_q  <= '0;
            last_wr_q <= '0;
        end else if (state_q == S_IDLE && start_i) begin
            wr_seen_q <= 1'b0;
            wr_cnt_q  <= '0;
        end else if (mem_req_o && mem_we_o) begin
            wr_seen_q <= 1'b1;
            wr_cnt_q  <= wr_cnt_q + WCNT_W'(1);
            last_wr_q <= mem_addr_o;
        end
    end

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !wr_seen_q);  // R11
    AST_COMMIT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cpl_q) || !$stable(esp_q) || !$stable(ss_q) || !$stable(eip_q)) |-> done_o);  // R10
    AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wr_cnt_q == WCNT_W'(pcnt_q) + WCNT_W'(4)));  // R8
    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && wr_seen_q) |-> (mem_addr_o == last_wr_q - isz));  // R9
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));  // R12
    AST_WRITE_NOT_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);  // R12
endmodule

// File: tb/gate_stack_switch_test.sv
`timescale 1ns/1ps
module gate_stack_switch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cur_tss, code_sel, old_cs, old_ss;
    logic [31:0] tss_base, tss_limit, gate_offset, old_eip, old_esp, old_ss_base;
    logic        tss_wide, gate_wide;
    logic [1:0]  code_dpl, ss_dpl;
    logic [7:0]  gate_pcnt;
    logic        ss_in_range, ss_present, ss_writable;
    logic [31:0] ss_base, ss_limit;
    logic [15:0] ss_sel;
    logic        mem_req, mem_we, mem_wide;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_kind, cpl;
    logic [15:0] fault_sel, cs, ss;
    logic [31:0] eip, esp;

    always #2.5 clk = ~clk;

    gate_stack_switch uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cur_tss_sel_i(cur_tss),
        .tss_base_i(tss_base), .tss_limit_i(tss_limit), .tss_wide_i(tss_wide),
        .code_sel_i(code_sel), .code_dpl_i(code_dpl), .gate_wide_i(gate_wide),
        .gate_offset_i(gate_offset), .gate_pcnt_i(gate_pcnt), .old_cs_i(old_cs),
        .old_eip_i(old_eip), .old_ss_i(old_ss), .old_esp_i(old_esp),
        .old_ss_base_i(old_ss_base), .ss_sel_o(ss_sel), .ss_in_range_i(ss_in_range),
        .ss_present_i(ss_present), .ss_dpl_i(ss_dpl), .ss_writable_i(ss_writable),
        .ss_base_i(ss_base), .ss_limit_i(ss_limit), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_wide_o(mem_wide), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy),
        .done_o(done), .fault_o(fault), .fault_kind_o(fault_kind),
        .fault_sel_o(fault_sel), .cpl_o(cpl), .cs_o(cs), .eip_o(eip),
        .ss_o(ss), .esp_o(esp)
    );

    // Byte memory, registered reads
    logic [7:0] mem [0:4095];
    int n_writes;
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            n_writes = n_writes + 1;
            mem[mem_addr[11:0]]         = mem_wdata[7:0];
            mem[mem_addr[11:0] + 12'd1] = mem_wdata[15:8];
            if (mem_wide) begin
                mem[mem_addr[11:0] + 12'd2] = mem_wdata[23:16];
                mem[mem_addr[11:0] + 12'd3] = mem_wdata[31:24];
            end
        end else if (mem_req) begin
            mem_rdata <= {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                          mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
        end
    end

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic saw_done, saw_fault;
    logic [1:0]  x_cpl;
    logic [15:0] x_cs, x_ss;
    logic [31:0] x_eip, x_esp;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        n_writes = 0;
    endtask

    task automatic put16(input logic [31:0] a, input logic [15:0] d);
        mem[a[11:0]] = d[7:0];
        mem[a[11:0] + 12'd1] = d[15:8];
    endtask

    task automatic put32(input logic [31:0] a, input logic [31:0] d);
        put16(a, d[15:0]);
        put16(a + 32'd2, d[31:16]);
    endtask

    function automatic logic [31:0] get32(input logic [31:0] a);
        return {mem[a[11:0] + 12'd3], mem[a[11:0] + 12'd2], mem[a[11:0] + 12'd1], mem[a[11:0]]};
    endfunction

    function automatic logic [31:0] get16(input logic [31:0] a);
        return {16'h0, mem[a[11:0] + 12'd1], mem[a[11:0]]};
    endfunction

    task automatic run_op();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        saw_done = done;
        saw_fault = fault;
    endtask

    task automatic check_arch(input string req);
        check(req, {30'h0, cpl}, {30'h0, x_cpl});
        check(req, {16'h0, cs}, {16'h0, x_cs});
        check(req, eip, x_eip);
        check(req, {16'h0, ss}, {16'h0, x_ss});
        check(req, esp, x_esp);
    endtask

    task automatic expect_fault(input string req, input logic [1:0] kind, input logic [15:0] sel);
        run_op();
        check(req, {31'h0, saw_fault}, 32'h1);
        check(req, {30'h0, fault_kind}, {30'h0, kind});
        check(req, {16'h0, fault_sel}, {16'h0, sel});
        check({req, " R11 no write"}, n_writes, 0);
        check_arch({req, " R11 state kept"});
        @(negedge clk);
        check("R11 fault pulse", {31'h0, fault}, 32'h0);
    endtask

    task automatic setup32();
        clear_mem();
        tss_wide = 1'b1; tss_base = 32'h100; tss_limit = 32'h67; cur_tss = 16'h0028;
        code_sel = 16'h0048; code_dpl = 2'd1;
        gate_wide = 1'b1; gate_offset = 32'h0001_2340; gate_pcnt = 8'hE3;
        old_cs = 16'h001B; old_eip = 32'h8000_1234; old_ss = 16'h0023;
        old_esp = 32'h100; old_ss_base = 32'h400;
        ss_in_range = 1'b1; ss_present = 1'b1; ss_dpl = 2'd1; ss_writable = 1'b1;
        ss_base = 32'h800; ss_limit = 32'hFFFF;
        put32(32'h10C, 32'h200);
        put16(32'h110, 16'h0031);
        put32(32'h500, 32'hA0A0_0000);
        put32(32'h504, 32'hA1A1_0001);
        put32(32'h508, 32'hA2A2_0002);
    endtask

    task automatic setup16();
        clear_mem();
        tss_wide = 1'b0; tss_base = 32'h180; tss_limit = 32'h2B; cur_tss = 16'h0030;
        code_sel = 16'h0050; code_dpl = 2'd2;
        gate_wide = 1'b0; gate_offset = 32'hABCD_1234; gate_pcnt = 8'h22;
        old_cs = 16'h0057; old_eip = 32'h1234_5678; old_ss = 16'h005F;
        old_esp = 32'h40; old_ss_base = 32'h600;
        ss_in_range = 1'b1; ss_present = 1'b1; ss_dpl = 2'd2; ss_writable = 1'b1;
        ss_base = 32'hC00; ss_limit = 32'hFFFF;
        put16(32'h18A, 16'h0120);
        put16(32'h18C, 16'h003A);
        put16(32'h640, 16'hB000);
        put16(32'h642, 16'hB001);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 done", {31'h0, done}, 32'h0);
        check("R1 fault", {31'h0, fault}, 32'h0);
        x_cpl = 0; x_cs = 0; x_eip = 0; x_ss = 0; x_esp = 0;
        check_arch("R1 committed");
    endtask

    task automatic t_call32();
        setup32();
        run_op();
        check("R10 done", {31'h0, saw_done}, 32'h1);
        check("R2 R8 old ss", get32(32'h9FC), 32'h0000_0023);
        check("R8 old esp", get32(32'h9F8), 32'h0000_0100);
        check("R8 deepest param", get32(32'h9F4), 32'hA2A2_0002);
        check("R8 middle param", get32(32'h9F0), 32'hA1A1_0001);
        check("R8 top param", get32(32'h9EC), 32'hA0A0_0000);
        check("R9 old cs", get32(32'h9E8), 32'h0000_001B);
        check("R8 old eip", get32(32'h9E4), 32'h8000_1234);
        check("R7 writes", n_writes, 7);
        check("R8 below untouched", get32(32'h9E0), 32'h0);
        x_cpl = 2'd1; x_cs = 16'h0049; x_eip = 32'h0001_2340; x_ss = 16'h0031; x_esp = 32'h1E4;
        check_arch("R10 commit32");
        @(negedge clk);
        check("R10 done pulse", {31'h0, done}, 32'h0);
    endtask

    task automatic t_call16();
        setup16();
        run_op();
        check("R3 done", {31'h0, saw_done}, 32'h1);
        check("R9 old ss", get16(32'hD1E), 32'h005F);
        check("R9 old esp low", get16(32'hD1C), 32'h0040);
        check("R8 deepest param16", get16(32'hD1A), 32'hB001);
        check("R8 top param16", get16(32'hD18), 32'hB000);
        check("R9 old cs16", get16(32'hD16), 32'h0057);
        check("R9 old eip low", get16(32'hD14), 32'h5678);
        check("R9 above untouched", get16(32'hD20), 32'h0);
        check("R7 writes16", n_writes, 6);
        x_cpl = 2'd2; x_cs = 16'h0052; x_eip = 32'h0000_1234; x_ss = 16'h003A; x_esp = 32'h114;
        check_arch("R3 R10 commit16");
    endtask

    task automatic t_tss_limits();
        setup32(); tss_limit = 32'h12;
        expect_fault("R2 limit over", 2'd1, 16'h0028);
        setup32(); tss_limit = 32'h13;
        run_op();
        check("R2 limit exact", {31'h0, saw_done}, 32'h1);
        x_cpl = 2'd1; x_cs = 16'h0049; x_eip = 32'h0001_2340; x_ss = 16'h0031; x_esp = 32'h1E4;
        setup16(); tss_limit = 32'h0D;
        expect_fault("R3 limit over", 2'd1, 16'h0030);
        setup16(); tss_limit = 32'h0E;
        run_op();
        check("R3 limit exact", {31'h0, saw_done}, 32'h1);
        x_cpl = 2'd2; x_cs = 16'h0052; x_eip = 32'h0000_1234; x_ss = 16'h003A; x_esp = 32'h114;
    endtask

    task automatic t_ts_causes();
        setup32(); put16(32'h110, 16'h0001);
        expect_fault("R4 null", 2'd1, 16'h0001);
        setup32(); ss_in_range = 1'b0;
        expect_fault("R4 range", 2'd1, 16'h0031);
        setup32(); put16(32'h110, 16'h0032);
        expect_fault("R4 rpl", 2'd1, 16'h0032);
        setup32(); ss_dpl = 2'd2;
        expect_fault("R4 dpl", 2'd1, 16'h0031);
        setup32(); ss_writable = 1'b0;
        expect_fault("R4 writable", 2'd1, 16'h0031);
        setup32(); ss_present = 1'b0; ss_dpl = 2'd3;
        expect_fault("R4 priority over R5", 2'd1, 16'h0031);
        setup32(); ss_present = 1'b0;
        expect_fault("R5 not present", 2'd2, 16'h0031);
    endtask

    task automatic t_room();
        setup32(); put32(32'h10C, 32'h1B);
        expect_fault("R6 esp short", 2'd2, 16'h0031);
        setup32(); ss_limit = 32'h1FE;
        expect_fault("R6 limit short", 2'd2, 16'h0031);
        setup32(); ss_limit = 32'h1FF;
        run_op();
        check("R6 limit exact", {31'h0, saw_done}, 32'h1);
        setup32(); put32(32'h10C, 32'h1C);
        run_op();
        check("R6 esp exact", {31'h0, saw_done}, 32'h1);
        check("R6 esp exact final", esp, 32'h0);
        check("R6 bottom item", get32(32'h800), 32'h8000_1234);
        x_cpl = 2'd1; x_cs = 16'h0049; x_eip = 32'h0001_2340; x_ss = 16'h0031; x_esp = 32'h0;
    endtask

    task automatic t_mask();
        setup32(); gate_pcnt = 8'hE0;
        run_op();
        check("R7 zero count done", {31'h0, saw_done}, 32'h1);
        check("R7 zero count writes", n_writes, 4);
        check("R7 cs follows esp", get32(32'h9F4), 32'h0000_001B);
        check("R7 eip last", get32(32'h9F0), 32'h8000_1234);
        check("R7 final esp", esp, 32'h1F0);
        x_esp = 32'h1F0;
    endtask

    task automatic t_start_ignored();
        setup32();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R12 busy after start", {31'h0, busy}, 32'h1);
        @(negedge clk);
        gate_offset = 32'h0BAD_0BAD; gate_pcnt = 8'h01; code_dpl = 2'd3;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        check("R12 done", {31'h0, done}, 32'h1);
        check("R12 start ignored eip", eip, 32'h0001_2340);
        check("R12 start ignored writes", n_writes, 7);
        @(negedge clk);
        check("R12 idle after", {31'h0, busy}, 32'h0);
        x_eip = 32'h0001_2340; x_esp = 32'h1E4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        setup32();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_call32();
        t_call16();
        t_tss_limits();
        t_ts_causes();
        t_room();
        t_mask();
        t_start_ignored();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule